// File: doc/BRIEF.md
# Clock Servo: Filtered PI Frequency Control with Lock Tracking

This block closes the loop of a time-synchronisation engine. Each time a new signed clock offset (in nanoseconds) is presented with a valid strobe, the servo smooths it through a first-order IIR stage and feeds the result to a proportional-integral controller. The controller produces a signed frequency correction in parts per billion for a downstream clock NCO. Both gains are programmable fixed-point values with sixteen fractional bits. The integrator has an anti-windup clamp, and the final correction saturates at a symmetric limit.

When an offset is too large to slew away, the servo gives up on frequency control for that sample. It issues a one-cycle phase-step request carrying the offset, and it starts the loop again from a clean state. In parallel, a three-state detector with separate enter and exit thresholds reports whether the loop is unlocked, acquiring or locked. The detector has hysteresis so that it does not chatter near a single threshold.

Top module: `clk_servo_pi`

## Requirements
- R1: While reset is held and after it is released, before any sample arrives: adj_ppb is 0, adj_vld is 0, step_req is 0, step_ns is 0 and lock_st is 0 (unlocked).
- R2: A valid sample whose magnitude is at most step_thr_ns produces exactly one cycle of adj_vld, starting on the clock edge that captures the sample. Cycles without offs_vld produce no adj_vld, and offs_ns has no effect on any output while offs_vld is low.
- R3: The filter state starts at 0. Each non-step sample x updates it to f + floor((x - f) / 8), where f is the previous filter state. The division is an arithmetic right shift by 3.
- R4: kp_gain and ki_gain are unsigned values with 16 fractional bits. The integrator accumulates ki_gain times the new filter value. The output is floor((kp_gain * filter + integrator) / 65536), where the division is an arithmetic shift.
- R5: The integrator is clamped to plus or minus INTEG_LIM * 65536. With kp_gain = 0, the output therefore never moves beyond plus or minus INTEG_LIM ppb.
- R6: adj_ppb is saturated to the range -OUT_LIM to +OUT_LIM ppb. The default OUT_LIM is 500000.
- R7: A sample with |offs_ns| strictly greater than step_thr_ns raises step_req for one cycle, with step_ns equal to that offset. On that edge adj_vld stays 0 and adj_ppb becomes 0. A magnitude equal to the threshold is not a step.
- R8: A step clears the filter and the integrator, so the next sample is processed exactly as if it were the first after reset.
- R9: lock_st is encoded as 0 unlocked, 1 acquiring and 2 locked. From unlocked, a sample with |offs_ns| < lock_enter_ns moves the detector to acquiring and counts as the first good sample. The detector reaches locked on the LOCK_N-th consecutive such sample.
- R10: In acquiring, a sample with |offs_ns| >= lock_enter_ns returns the detector to unlocked and discards the count.
- R11: In locked, a sample with |offs_ns| > lock_exit_ns returns the detector to unlocked. Samples at or below lock_exit_ns keep it locked, even when they are at or above lock_enter_ns.
- R12: A phase step forces lock_st to unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offs_vld | input | 1 | Offset sample strobe |
| offs_ns | input | OFS_W | Signed offset in ns |
| kp_gain | input | GAIN_W | Proportional gain, 16 fractional bits |
| ki_gain | input | GAIN_W | Integral gain, 16 fractional bits |
| step_thr_ns | input | OFS_W | Phase-step threshold in ns |
| lock_enter_ns | input | OFS_W | Threshold for entering lock |
| lock_exit_ns | input | OFS_W | Threshold for leaving lock |
| adj_vld | output | 1 | New frequency correction strobe |
| adj_ppb | output | ADJ_W | Signed frequency correction in ppb |
| step_req | output | 1 | Phase-step request pulse |
| step_ns | output | OFS_W | Signed step amount in ns |
| lock_st | output | 2 | Lock state |

## Verification
The bench builds the servo with LOCK_N = 3 so that every path through the lock detector takes only a few samples. It sets INTEG_LIM = 2000 so that the anti-windup clamp is reached after about twenty moderate samples, rather than the millions that the 100 ms default would need. OUT_LIM and the word widths stay at their defaults, so saturation is exercised at the real plus or minus 500000 ppb limit. To reach that limit, the bench raises the step threshold and the proportional gain.

// File: rtl/servo_pkg.sv
package servo_pkg;
  localparam int ACC_W = 64;
  typedef logic signed [ACC_W-1:0] acc_t;

  typedef enum logic [1:0] {
    LK_UNLOCKED  = 2'd0,
    LK_ACQUIRING = 2'd1,
    LK_LOCKED    = 2'd2
  } lock_e;

  // symmetric saturation to [-lim, +lim]
  function automatic acc_t clamp_sym(input acc_t v, input acc_t lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  // first-order IIR with shift coefficient: f + (x - f) / 2^sh, floored
  function automatic acc_t lpf_next(input acc_t f, input acc_t x, input int sh);
    return f + ((x - f) >>> sh);
  endfunction

  // PI output before saturation, Q16.16 products rescaled to integer ppb
  function automatic acc_t pi_out(input acc_t kp, input acc_t filt, input acc_t integ);
    return ((kp * filt) + integ) >>> 16;
  endfunction
endpackage

// File: rtl/servo_step_gate.sv
module servo_step_gate #(
  parameter int OFS_W = 32
) (
  input  logic                    offs_vld,
  input  logic signed [OFS_W-1:0] offs_ns,
  input  logic        [OFS_W-1:0] step_thr_ns,
  output logic        [OFS_W:0]   abs_ofs,
  output logic                    is_step,
  output logic                    is_fine
);
  logic signed [OFS_W:0] ext;

  always_comb begin
    ext     = {offs_ns[OFS_W-1], offs_ns};
    abs_ofs = (ext < 0) ? $unsigned(-ext) : $unsigned(ext);
    is_step = offs_vld && (abs_ofs > {1'b0, step_thr_ns});
    is_fine = offs_vld && !is_step;
  end
endmodule

// File: rtl/servo_pi_core.sv
module servo_pi_core
  import servo_pkg::*;
#(
  parameter int    OFS_W     = 32,
  parameter int    GAIN_W    = 24,
  parameter int    ADJ_W     = 32,
  parameter int    LPF_SHIFT = 3,
  parameter longint INTEG_LIM = 64'd100_000_000,
  parameter longint OUT_LIM   = 64'd500_000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  logic                    clr,
  input  logic signed [OFS_W-1:0] offs_ns,
  input  logic        [GAIN_W-1:0] kp_gain,
  input  logic        [GAIN_W-1:0] ki_gain,
  output logic                    adj_vld,
  output logic signed [ADJ_W-1:0] adj_ppb
);
  localparam acc_t ILIM = acc_t'(INTEG_LIM) * 65536;
  localparam acc_t OLIM = acc_t'(OUT_LIM);

  acc_t filt_q, integ_q;
  acc_t x_ext, kp_ext, ki_ext;
  acc_t filt_n, integ_n, out_raw, out_sat;

  always_comb begin
    x_ext   = {{(ACC_W-OFS_W){offs_ns[OFS_W-1]}}, offs_ns};
    kp_ext  = {{(ACC_W-GAIN_W){1'b0}}, kp_gain};
    ki_ext  = {{(ACC_W-GAIN_W){1'b0}}, ki_gain};
    filt_n  = lpf_next(filt_q, x_ext, LPF_SHIFT);
    integ_n = clamp_sym(integ_q + ki_ext * filt_n, ILIM);
    out_raw = pi_out(kp_ext, filt_n, integ_n);
    out_sat = clamp_sym(out_raw, OLIM);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      filt_q  <= '0;
      integ_q <= '0;
      adj_ppb <= '0;
      adj_vld <= 1'b0;
    end else if (upd) begin
      filt_q  <= filt_n;
      integ_q <= integ_n;
      adj_ppb <= out_sat[ADJ_W-1:0];
      adj_vld <= 1'b1;
    end else begin
      adj_vld <= 1'b0;
    end
  end

  // R5: accumulated integral term stays inside the anti-windup window
  p_integ_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_q <= ILIM) && (integ_q >= -ILIM));

  // R6: published correction never leaves the saturation band
  p_out_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_t'(adj_ppb) <= OLIM) && (acc_t'(adj_ppb) >= -OLIM));

  // R8: a clear leaves the output at zero with no strobe
  p_clr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (adj_ppb == '0) && !adj_vld);
endmodule

// File: rtl/servo_lock_fsm.sv
module servo_lock_fsm
  import servo_pkg::*;
#(
  parameter int OFS_W  = 32,
  parameter int LOCK_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             clr,
  input  logic [OFS_W:0]   abs_ofs,
  input  logic [OFS_W-1:0] lock_enter_ns,
  input  logic [OFS_W-1:0] lock_exit_ns,
  output lock_e            lock_st
);
  localparam int CNT_W = $clog2(LOCK_N + 1);

  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             below_enter, above_exit;

  always_comb begin
    below_enter = abs_ofs < {1'b0, lock_enter_ns};
    above_exit  = abs_ofs > {1'b0, lock_exit_ns};
    cnt_inc     = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      lock_st <= LK_UNLOCKED;
      cnt_q   <= '0;
    end else if (upd) begin
      case (lock_st)
        LK_UNLOCKED: if (below_enter) begin
          cnt_q   <= CNT_W'(1);
          lock_st <= (LOCK_N <= 1) ? LK_LOCKED : LK_ACQUIRING;
        end
        LK_ACQUIRING: if (!below_enter) begin
          cnt_q   <= '0;
          lock_st <= LK_UNLOCKED;
        end else if (cnt_inc == CNT_W'(LOCK_N)) begin
          cnt_q   <= '0;
          lock_st <= LK_LOCKED;
        end else begin
          cnt_q   <= cnt_inc;
        end
        default: if (above_exit) begin
          cnt_q   <= '0;
          lock_st <= LK_UNLOCKED;
        end
      endcase
    end
  end

  // R9: locked is entered only from acquiring
  p_lock_via_acq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock_st == LK_LOCKED) && ($past(lock_st) != LK_LOCKED)) |-> ($past(lock_st) == LK_ACQUIRING));

  // R9: the unused encoding never appears
  p_lock_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_st != 2'd3);

  // R11: a sample beyond the exit threshold ends lock
  p_exit_unlock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr && (lock_st == LK_LOCKED) && above_exit) |=> (lock_st == LK_UNLOCKED));
endmodule

// File: rtl/clk_servo_pi.sv
module clk_servo_pi
  import servo_pkg::*;
#(
  parameter int     OFS_W     = 32,
  parameter int     GAIN_W    = 24,
  parameter int     ADJ_W     = 32,
  parameter int     LPF_SHIFT = 3,
  parameter int     LOCK_N    = 8,
  parameter longint INTEG_LIM = 64'd100_000_000,
  parameter longint OUT_LIM   = 64'd500_000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     offs_vld,
  input  logic signed [OFS_W-1:0]  offs_ns,
  input  logic        [GAIN_W-1:0] kp_gain,
  input  logic        [GAIN_W-1:0] ki_gain,
  input  logic        [OFS_W-1:0]  step_thr_ns,
  input  logic        [OFS_W-1:0]  lock_enter_ns,
  input  logic        [OFS_W-1:0]  lock_exit_ns,
  output logic                     adj_vld,
  output logic signed [ADJ_W-1:0]  adj_ppb,
  output logic                     step_req,
  output logic signed [OFS_W-1:0]  step_ns,
  output logic        [1:0]        lock_st
);
  logic [OFS_W:0] abs_ofs;
  logic           is_step, is_fine;
  lock_e          lock_q;

  servo_step_gate #(.OFS_W(OFS_W)) u_gate (
    .offs_vld(offs_vld), .offs_ns(offs_ns), .step_thr_ns(step_thr_ns),
    .abs_ofs(abs_ofs), .is_step(is_step), .is_fine(is_fine)
  );

  servo_pi_core #(
    .OFS_W(OFS_W), .GAIN_W(GAIN_W), .ADJ_W(ADJ_W), .LPF_SHIFT(LPF_SHIFT),
    .INTEG_LIM(INTEG_LIM), .OUT_LIM(OUT_LIM)
  ) u_pi (
    .clk(clk), .rst_n(rst_n), .upd(is_fine), .clr(is_step), .offs_ns(offs_ns),
    .kp_gain(kp_gain), .ki_gain(ki_gain), .adj_vld(adj_vld), .adj_ppb(adj_ppb)
  );

  servo_lock_fsm #(.OFS_W(OFS_W), .LOCK_N(LOCK_N)) u_lock (
    .clk(clk), .rst_n(rst_n), .upd(is_fine), .clr(is_step), .abs_ofs(abs_ofs),
    .lock_enter_ns(lock_enter_ns), .lock_exit_ns(lock_exit_ns), .lock_st(lock_q)
  );

  assign lock_st = lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_req <= 1'b0;
      step_ns  <= '0;
    end else begin
      step_req <= is_step;
      if (is_step) step_ns <= offs_ns;
    end
  end

  // R7: a step request and a frequency update never share a cycle
  p_step_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_req && adj_vld));

  // R7: the step amount is the offset that triggered it
  p_step_amt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_req |-> (step_ns == $past(offs_ns)));

  // R12: the lock tracker is unlocked whenever a step is requested
  p_step_unlock_r12: assert property (@(posedge clk) disable iff (!rst_n)
    step_req |-> (lock_st == 2'd0));

  // R2: every correction strobe answers a sample strobe
  p_adj_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adj_vld |-> $past(offs_vld));
endmodule

// File: tb/sim_clk_servo_pi.sv
module sim_clk_servo_pi;
  localparam int     OFS_W  = 32;
  localparam int     GAIN_W = 24;
  localparam int     ADJ_W  = 32;
  localparam int     LOCKN  = 3;
  localparam longint ILIM   = 2000;
  localparam longint OLIM   = 500000;
  localparam int     NV     = 16;

  // {expected lock[1:0], offset[31:0]}; thr 1000, enter 100, exit 300
  localparam logic [33:0] VEC [NV] = '{
    {2'd1, 32'sd50},    {2'd1, -32'sd80},   {2'd2, 32'sd20},   {2'd2, 32'sd250},
    {2'd0, -32'sd310},  {2'd1, 32'sd90},    {2'd0, 32'sd150},  {2'd0, 32'sd100},
    {2'd0, 32'sd1000},  {2'd0, -32'sd1001}, {2'd1, 32'sd0},    {2'd1, 32'sd99},
    {2'd2, -32'sd99},   {2'd2, 32'sd300},   {2'd0, 32'sd1200}, {2'd0, -32'sd500}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic offs_vld = 1'b0;
  logic signed [OFS_W-1:0] offs_ns = '0;
  logic [GAIN_W-1:0] kp_gain = 24'd32768;
  logic [GAIN_W-1:0] ki_gain = 24'd3277;
  logic [OFS_W-1:0] step_thr_ns = 32'd1000;
  logic [OFS_W-1:0] lock_enter_ns = 32'd100;
  logic [OFS_W-1:0] lock_exit_ns = 32'd300;
  logic adj_vld, step_req;
  logic signed [ADJ_W-1:0] adj_ppb;
  logic signed [OFS_W-1:0] step_ns;
  logic [1:0] lock_st;

  int n_run = 0;
  int n_fail = 0;
  longint m_filt = 0;
  longint m_integ = 0;
  longint m_adj = 0;

  always #2 clk = ~clk;

  clk_servo_pi #(.OFS_W(OFS_W), .GAIN_W(GAIN_W), .ADJ_W(ADJ_W), .LOCK_N(LOCKN),
                 .INTEG_LIM(ILIM), .OUT_LIM(OLIM)) u0 (
    .clk(clk), .rst_n(rst_n), .offs_vld(offs_vld), .offs_ns(offs_ns),
    .kp_gain(kp_gain), .ki_gain(ki_gain), .step_thr_ns(step_thr_ns),
    .lock_enter_ns(lock_enter_ns), .lock_exit_ns(lock_exit_ns),
    .adj_vld(adj_vld), .adj_ppb(adj_ppb), .step_req(step_req),
    .step_ns(step_ns), .lock_st(lock_st)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint lim(input longint v, input longint l);
    return (v > l) ? l : ((v < -l) ? -l : v);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_filt = 0; m_integ = 0; m_adj = 0;
  endtask

  // one sample; reference model derived from R3..R8
  task automatic sample(input longint o, input bit chk_lock, input logic [1:0] elock);
    longint mag;
    bit     stp;
    mag = (o < 0) ? -o : o;
    stp = mag > longint'(step_thr_ns);
    if (stp) begin
      m_filt = 0; m_integ = 0; m_adj = 0;
    end else begin
      m_filt  = m_filt + ((o - m_filt) >>> 3);
      m_integ = lim(m_integ + longint'(ki_gain) * m_filt, ILIM * 65536);
      m_adj   = lim((longint'(kp_gain) * m_filt + m_integ) >>> 16, OLIM);
    end
    @(negedge clk);
    offs_vld = 1'b1;
    offs_ns  = OFS_W'(o);
    @(negedge clk);
    offs_vld = 1'b0;
    check("R2 adj_vld pulse", longint'(adj_vld), longint'(!stp));
    check("R3/R4/R6 adj_ppb", longint'(adj_ppb), m_adj);
    check("R7 step_req", longint'(step_req), longint'(stp));
    if (stp) check("R7 step_ns", longint'(step_ns), o);
    if (stp) check("R12 lock after step", longint'(lock_st), 0);
    if (chk_lock) check("R9/R10/R11 lock_st", longint'(lock_st), longint'(elock));
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    longint hold;
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    check("R1 adj_ppb", longint'(adj_ppb), 0);
    check("R1 adj_vld", longint'(adj_vld), 0);
    check("R1 step_req", longint'(step_req), 0);
    check("R1 lock_st", longint'(lock_st), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 step_ns after release", longint'(step_ns), 0);

    for (int i = 0; i < NV; i++) begin
      sample(longint'($signed(VEC[i][31:0])), 1'b1, VEC[i][33:32]);
      if (i == 10) check("R8 fresh start after step", longint'(adj_ppb), 0);
    end

    // R2: offs_ns ignored while offs_vld is low
    hold = longint'(adj_ppb);
    offs_ns = 32'sd777777;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R2 no strobe when idle", longint'(adj_vld), 0);
      check("R2 adj held when idle", longint'(adj_ppb), hold);
      check("R2 no step when idle", longint'(step_req), 0);
    end

    // R6: saturation in both directions
    do_reset();
    kp_gain = 24'd8388608; ki_gain = 24'd0; step_thr_ns = 32'd1000000;
    sample(800000, 1'b0, 2'd0);
    check("R6 positive saturation", longint'(adj_ppb), OLIM);
    sample(-800000, 1'b0, 2'd0);
    check("R6 negative saturation", longint'(adj_ppb), -OLIM);

    // R5: integrator windup is bounded
    do_reset();
    kp_gain = 24'd0; ki_gain = 24'd65536; step_thr_ns = 32'd1000;
    for (int k = 0; k < 40; k++) sample(800, 1'b0, 2'd0);
    check("R5 integrator clamp", longint'(adj_ppb), ILIM);
    for (int k = 0; k < 40; k++) sample(-800, 1'b0, 2'd0);
    check("R5 negative integrator clamp", longint'(adj_ppb), -ILIM);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule